// File: doc/BRIEF.md
# Shared-Select Device Address Filter

This block sits in the host interface of a peripheral that shares one active-low chip-select line with up to three sibling devices. Each device has a 2-bit identity set by two static strap pins. At the start of every transaction the host sends a 2-bit target address. This block captures that address, compares it with the strap, and raises an enable to the internal core only when the two agree. The core receives just that enable and the stored address. A read output-enable keeps the shared read bus tri-stated on every device that is not selected.

In parallel mode, the address is taken from two data lines on the first falling strobe edge after chip select falls. In serial mode, the address is taken from the 7th and 8th rising serial-clock edges, which are the two least significant bits of the first byte. Address filtering always applies in parallel mode. In serial mode it applies only when a flag pin is high at reset release.

All asynchronous host pins are synchronized into the core clock, and every edge is detected in that domain. The stored address resets to 00, so after reset a transaction with no address goes to the device strapped 00. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `chip_addr_sel`

## Requirements
- R1: While reset is held, and after its release, the stored address `rx_addr` is 00. `ready` is then high only on a device whose strap is 00.
- R2: In parallel mode (`serial_mode`=0), the first falling edge of `stb_n` after `cs_n` falls stores `pd_addr[1]` as bit 1 and `pd_addr[0]` as bit 0 of `rx_addr`.
- R3: Further strobe edges within the same chip-select assertion leave `rx_addr` unchanged.
- R4: In serial mode with filtering on, bits are sent MSB first. The `si` value at the 7th rising edge of `sck_n` becomes bit 1 of `rx_addr`, and the value at the 8th rising edge becomes bit 0. The update takes effect after the 8th edge.
- R5: `pd_flag` is latched on the first clock after reset release. If it is 0 and `serial_mode`=1, no address is captured, `ready` is 1, and `core_en` follows chip select with no compare.
- R6: In parallel mode, filtering applies whatever value `pd_flag` had at reset release.
- R7: When chip select is asserted and no address is sent, the compare uses the stored address. This makes device 00 respond after reset.
- R8: `core_en` is high only while chip select is active and either the stored address equals `strap_addr` or filtering is off. It drops when chip select rises.
- R9: `ready` is high exactly when the stored address equals `strap_addr`, or when filtering is off.
- R10: `rd_oe` is high only when `core_en` and `core_rd` are both high. Otherwise the read bus stays undriven.
- R11: A serial transfer cut short before the 8th rising clock edge leaves `rx_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_mode | input | 1 | 1 selects serial mode, 0 selects parallel mode (static) |
| strap_addr | input | 2 | Static device identity pins |
| cs_n | input | 1 | Shared chip select, active low, asynchronous |
| stb_n | input | 1 | Parallel strobe, active low, asynchronous |
| sck_n | input | 1 | Serial clock; data is sampled on its rising edge |
| si | input | 1 | Serial data in |
| pd_addr | input | 2 | Parallel data lines that carry the address |
| pd_flag | input | 1 | Serial filter enable, latched at reset release |
| core_rd | input | 1 | Core requests to drive read data |
| core_en | output | 1 | Core command/data enable |
| rd_oe | output | 1 | Read-data output enable |
| ready | output | 1 | High when this device can be accessed |
| rx_addr | output | 2 | Stored host-sent address |

## Verification
The hardest cases to reach are those that depend on state fixed at reset release: the serial filter flag, and the 00 default before any address has been sent. The bench therefore resets the block several times with different mode and flag settings, and it checks a select with no address sent right after each reset. A second hard case is a serial transfer cut off after six clocks. Random addresses and straps are mixed with these directed partial bytes and repeated strobes, and every result is compared with a bench model of the stored address.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/cas_sync.sv
module cas_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cas_capture.sv
module cas_capture
  import cas_pkg::*;
#(
  parameter int SER_BITS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  serial_mode,
  input  logic  sel_on,
  input  logic  cs_s,
  input  logic  stb_s,
  input  logic  sck_s,
  input  logic  si_s,
  input  addr_t pd_s,
  output logic  cs_act,
  output addr_t rx_addr
);
  localparam int CNT_W  = $clog2(SER_BITS + 1);
  localparam int HI_POS = SER_BITS - 2;
  localparam int LO_POS = SER_BITS - 1;

  logic             cs_q, stb_q, sck_q;
  logic             armed, hi_bit;
  logic [CNT_W-1:0] cnt;
  logic             cs_fall, stb_fall, sck_rise;

  assign cs_act   = ~cs_s;
  assign cs_fall  = cs_q & ~cs_s;
  assign stb_fall = stb_q & ~stb_s;
  assign sck_rise = ~sck_q & sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      stb_q   <= 1'b1;
      sck_q   <= 1'b1;
      armed   <= 1'b0;
      hi_bit  <= 1'b0;
      cnt     <= '0;
      rx_addr <= '0;
    end else begin
      cs_q  <= cs_s;
      stb_q <= stb_s;
      sck_q <= sck_s;
      if (cs_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (!cs_act) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (!serial_mode) begin
          if (stb_fall) begin
            rx_addr <= pd_s;
            armed   <= 1'b0;
          end
        end else if (sel_on && sck_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(HI_POS)) hi_bit <= si_s;
          if (cnt == CNT_W'(LO_POS)) begin
            rx_addr <= {hi_bit, si_s};
            armed   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/chip_addr_sel.sv
module chip_addr_sel
  import cas_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SER_BITS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serial_mode,
  input  logic [1:0] strap_addr,
  input  logic       cs_n,
  input  logic       stb_n,
  input  logic       sck_n,
  input  logic       si,
  input  logic [1:0] pd_addr,
  input  logic       pd_flag,
  input  logic       core_rd,
  output logic       core_en,
  output logic       rd_oe,
  output logic       ready,
  output logic [1:0] rx_addr
);
  localparam int SYNC_W = 4 + ADDR_W;

  logic [SYNC_W-1:0] raw_v, sync_v;
  logic              flag_q, flag_done;
  logic              sel_on, cs_act, match;
  addr_t             stored;

  assign raw_v = {cs_n, stb_n, sck_n, si, pd_addr};

  cas_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(sync_v)
  );

  // Filter flag is sampled once, on the first clock after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b1;
      flag_done <= 1'b0;
    end else if (!flag_done) begin
      flag_q    <= pd_flag;
      flag_done <= 1'b1;
    end
  end

  assign sel_on = !serial_mode || flag_q;

  cas_capture #(.SER_BITS(SER_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .sel_on(sel_on),
    .cs_s(sync_v[SYNC_W-1]), .stb_s(sync_v[SYNC_W-2]),
    .sck_s(sync_v[SYNC_W-3]), .si_s(sync_v[SYNC_W-4]),
    .pd_s(sync_v[ADDR_W-1:0]), .cs_act(cs_act), .rx_addr(stored)
  );

  assign match   = (stored == strap_addr);
  assign ready   = !sel_on || match;
  assign core_en = cs_act && ready;
  assign rd_oe   = core_en && core_rd;
  assign rx_addr = stored;
endmodule

// File: rtl/cas_chk.sv
module cas_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       sel_on,
  input logic       core_en,
  input logic       rd_oe,
  input logic       ready,
  input logic [1:0] rx_addr,
  input logic [1:0] strap_addr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> rx_addr == 2'b00);
  // R8
  en_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) core_en |-> cs_act);
  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |-> !rd_oe);
  // R3
  capture_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_addr) |-> $past(cs_act));
  // R9
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_on && ready) |-> rx_addr == strap_addr);
  // R5
  bypass_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_on && cs_act) |-> core_en);
endmodule

bind chip_addr_sel cas_chk u_cas_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sel_on(sel_on),
  .core_en(core_en), .rd_oe(rd_oe), .ready(ready),
  .rx_addr(rx_addr), .strap_addr(strap_addr)
);

// File: tb/chip_addr_sel_bench.sv
module chip_addr_sel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic serial_mode = 1'b0, cs_n = 1'b1, stb_n = 1'b1, sck_n = 1'b1, si = 1'b0;
  logic pd_flag = 1'b0, core_rd = 1'b0;
  logic [1:0] strap_addr = 2'b00, pd_addr = 2'b00;
  logic core_en, rd_oe, ready;
  logic [1:0] rx_addr;
  int checks = 0, errors = 0;
  logic [1:0] exp_rx;
  logic bypass;
  int unused_seed;

  always #2 clk = ~clk;

  chip_addr_sel u_chip_addr_sel (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .strap_addr(strap_addr),
    .cs_n(cs_n), .stb_n(stb_n), .sck_n(sck_n), .si(si), .pd_addr(pd_addr),
    .pd_flag(pd_flag), .core_rd(core_rd), .core_en(core_en), .rd_oe(rd_oe),
    .ready(ready), .rx_addr(rx_addr)
  );

  function automatic logic exp_ready(logic [1:0] st, logic [1:0] sa, logic byp);
    return byp || (st == sa);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req, logic in_txn);
    @(negedge clk);
    check({req, " rx_addr"}, rx_addr, exp_rx);
    check({req, " ready"}, ready, exp_ready(exp_rx, strap_addr, bypass));
    check({req, " core_en"}, core_en, in_txn && exp_ready(exp_rx, strap_addr, bypass));
    check({req, " rd_oe R10"}, rd_oe, in_txn && core_rd && exp_ready(exp_rx, strap_addr, bypass));
  endtask

  task automatic do_reset(logic ser, logic flag);
    @(negedge clk);
    rst_n = 1'b0; serial_mode = ser; pd_flag = flag;
    cs_n = 1'b1; stb_n = 1'b1; sck_n = 1'b1;
    cyc(3);
    @(negedge clk);
    check("R1 rx_addr in reset", rx_addr, 0);
    rst_n = 1'b1;
    cyc(3);
    @(negedge clk);
    pd_flag = ~flag;
    exp_rx = 2'b00;
    bypass = ser && !flag;
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; cyc(4);
  endtask

  task automatic cs_high();
    @(negedge clk); cs_n = 1'b1; cyc(4);
  endtask

  task automatic par_strobe(logic [1:0] a);
    @(negedge clk); pd_addr = a; cyc(3);
    @(negedge clk); stb_n = 1'b0; cyc(4);
    @(negedge clk); stb_n = 1'b1; pd_addr = $urandom; cyc(4);
  endtask

  task automatic ser_send(logic [7:0] b, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); si = b[i]; sck_n = 1'b0; cyc(3);
      @(negedge clk); sck_n = 1'b1; cyc(3);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'h5EED);
    exp_rx = 2'b00; bypass = 1'b0;
    // Parallel mode, flag low at release: filtering must still apply (R6)
    do_reset(1'b0, 1'b0);
    strap_addr = 2'b00; check_all("R1 strap00", 1'b0);
    strap_addr = 2'b01; check_all("R1 strap01", 1'b0);
    strap_addr = 2'b00; cs_low(); check_all("R7 default 00", 1'b1); cs_high();
    strap_addr = 2'b10; cs_low(); check_all("R7 other strap", 1'b1); cs_high();
    for (int k = 0; k < 40; k++) begin
      logic [1:0] a, a2;
      a = $urandom; a2 = ~a;
      strap_addr = (k < 4) ? a : 2'($urandom);
      core_rd = $urandom;
      cs_low(); par_strobe(a); exp_rx = a;
      check_all("R2 R6 parallel capture", 1'b1);
      par_strobe(a2);
      check_all("R3 repeat strobe", 1'b1);
      cs_high();
      check_all("R8 after cs rise", 1'b0);
    end
    // Serial with filtering
    do_reset(1'b1, 1'b1);
    strap_addr = 2'b11; check_all("R1 serial reset", 1'b0);
    for (int k = 0; k < 30; k++) begin
      logic [7:0] b;
      b = $urandom;
      strap_addr = (k[0]) ? b[1:0] : 2'($urandom);
      core_rd = $urandom;
      cs_low(); ser_send(b, 8); exp_rx = b[1:0];
      check_all("R4 serial capture", 1'b1);
      cs_high();
      check_all("R9 idle ready", 1'b0);
      b = $urandom;
      cs_low(); ser_send(b, 6); cs_high();
      check_all("R11 short transfer", 1'b0);
    end
    // Serial with filtering off
    do_reset(1'b1, 1'b0);
    strap_addr = 2'b11; core_rd = 1'b1;
    check_all("R5 bypass ready", 1'b0);
    cs_low(); check_all("R5 bypass enable", 1'b1);
    ser_send(8'h00, 8);
    check_all("R5 no capture", 1'b1);
    cs_high(); check_all("R8 bypass release", 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule